// File: doc/BRIEF.md
# Single-Channel Bus-Master Transfer Engine

This block moves a programmed number of elements between a peripheral data port and memory without processor involvement. Once the processor has configured it, the engine waits for the peripheral to raise its request. It then asks the processor for the system bus and, once the bus is granted, becomes bus master. For every element it reads from the source side and writes to the destination side on the following cycle. Each side's address can advance after every element by the element size, or stay fixed.

Two bus modes are offered. Burst mode keeps the bus until the whole block has moved. Cycle-stealing mode hands the bus back after each element, so the processor runs between elements. When the count runs out, a completion flag is raised, and an interrupt is raised with it if enabled. Circular operation instead rewinds the count and both addresses to their programmed starting values and carries on serving requests. While the bus is not granted, the processor reads and writes five registers: control (offset 0), status (1), count (2), peripheral address (3) and memory address (4).

Top module: `dma_xfer_engine`

## Requirements
- R1: After synchronous reset, bus_req and irq are 0 and all five registers read back as 0.
- R2: bus_req rises only when the control enable bit (bit 0) and request-enable bit (bit 1) are set, per_req is high and the count is nonzero. No memory or peripheral strobe is driven unless bus_grant is high.
- R3: Each element is a source read strobe followed by a destination write strobe on the next cycle. The direction bit (bit 5) selects peripheral-to-memory when 0 and memory-to-peripheral when 1. Write data is the returned read data with bits above the element size zeroed.
- R4: The size field (bits 9:8: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit) sets an address step of 1, 2 or 4. The peripheral address advances after each element only when bit 6 is set, and the memory address only when bit 7 is set; otherwise it holds. Address registers read back their current value.
- R5: When the element that brings the count to zero completes, status bit 0 is set. irq equals that flag ANDed with the interrupt-enable bit (bit 2). Writing 1 to status bit 0 clears the flag.
- R6: With circular mode (bit 3) clear, the enable bit clears itself when the block completes, and the count reads 0.
- R7: With circular mode set, completing a block reloads the count and both addresses with their programmed values. Enable stays set and later requests keep being served.
- R8: In burst mode (bit 4 clear), bus_req stays high for the whole block. In cycle-stealing mode (bit 4 set), bus_req drops after every element.
- R9: While the request-enable bit is clear, per_req is ignored and bus_req stays low.
- R10: While enable is set, writes to count, both addresses and control bits 3 to 9 are ignored. Enable, request-enable and interrupt-enable remain writable.
- R11: With a programmed count of zero, bus_req is never asserted even when enabled and requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = register write, 0 = read |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, valid the cycle after the access |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Request for bus ownership |
| bus_grant | input | 1 | Bus granted to the engine |
| mem_addr | output | ADDR_W | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Element-served pulse to the peripheral |
| per_addr | output | ADDR_W | Peripheral address |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, one cycle after per_rd |

## Verification
The bench builds the engine with ADDR_W = 16 and CNT_W = 6. Narrow addresses keep the address arithmetic and the computed source data patterns easy to follow, and a 6-bit count keeps every block short, so one run covers burst, cycle-stealing, circular rewind and both directions. The small count width also lets the zero-count case and the locked-configuration case sit beside full transfers in the same run.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  localparam int DATA_W = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RG_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RG_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RG_COUNT = 3'd2;
  localparam logic [REG_AW-1:0] RG_PADDR = 3'd3;
  localparam logic [REG_AW-1:0] RG_MADDR = 3'd4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RD, SQ_WR} seq_st_t;

  // Control word, LSB first: en, req_en, tcie, circ, steal, dir, pinc, minc, size[1:0]
  typedef struct packed {
    logic [1:0] size;
    logic       minc;
    logic       pinc;
    logic       dir;
    logic       steal;
    logic       circ;
    logic       tcie;
    logic       req_en;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz,
                                                  input logic [DATA_W-1:0] d);
    case (sz)
      2'd0:    return d & 32'h0000_00FF;
      2'd1:    return d & 32'h0000_FFFF;
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              adv,
  input  logic [2:0]        step,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur
);

  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      cur     <= '0;
    end else if (ld) begin
      start_q <= ld_val;
      cur     <= ld_val;
    end else if (wrap) begin
      cur <= start_q;
    end else if (adv) begin
      cur <= cur + ADDR_W'(step);
    end
  end

  // R4: with no load, advance or rewind the pointer holds
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !adv && !wrap) |=> $stable(cur));

endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_grant,
  input  logic              elem_done,
  input  logic [ADDR_W-1:0] per_cur,
  input  logic [ADDR_W-1:0] mem_cur,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cnt,
  output logic              tc,
  output logic              irq,
  output logic              cnt_nz,
  output logic              cnt_last,
  output logic              wrap,
  output logic              ld_per,
  output logic              ld_mem
);

  logic [CNT_W-1:0]  cnt_init;
  logic              wr_ok, rd_ok;
  ctrl_t             w_ctrl;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ok    = cpu_sel && cpu_wr && !bus_grant;
  assign rd_ok    = cpu_sel && !cpu_wr && !bus_grant;
  assign w_ctrl   = ctrl_t'(cpu_wdata[CTRL_W-1:0]);
  assign cnt_nz   = (cnt != '0);
  assign cnt_last = (cnt == CNT_W'(1));
  assign wrap     = elem_done && cnt_last && ctrl.circ;
  assign ld_per   = wr_ok && (cpu_addr == RG_PADDR) && !ctrl.en;
  assign ld_mem   = wr_ok && (cpu_addr == RG_MADDR) && !ctrl.en;
  assign irq      = tc && ctrl.tcie;

  always_comb begin
    case (cpu_addr)
      RG_CTRL:  rd_mux = DATA_W'(ctrl);
      RG_STAT:  rd_mux = DATA_W'(tc);
      RG_COUNT: rd_mux = DATA_W'(cnt);
      RG_PADDR: rd_mux = DATA_W'(per_cur);
      RG_MADDR: rd_mux = DATA_W'(mem_cur);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      cnt       <= '0;
      cnt_init  <= '0;
      tc        <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      if (wr_ok) begin
        case (cpu_addr)
          RG_CTRL: begin
            if (ctrl.en) begin
              ctrl.en     <= w_ctrl.en;
              ctrl.req_en <= w_ctrl.req_en;
              ctrl.tcie   <= w_ctrl.tcie;
            end else begin
              ctrl <= w_ctrl;
            end
          end
          RG_STAT: if (cpu_wdata[0]) tc <= 1'b0;
          RG_COUNT: if (!ctrl.en) begin
            cnt      <= cpu_wdata[CNT_W-1:0];
            cnt_init <= cpu_wdata[CNT_W-1:0];
          end
          default: ;
        endcase
      end
      if (elem_done) begin
        if (cnt_last) begin
          tc <= 1'b1;
          if (ctrl.circ) begin
            cnt <= cnt_init;
          end else begin
            cnt     <= '0;
            ctrl.en <= 1'b0;
          end
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
      if (rd_ok) cpu_rdata <= rd_mux;
    end
  end

  // R5: finishing the last element raises the completion flag
  a_r5_tc_set: assert property (@(posedge clk) disable iff (rst)
    (elem_done && cnt_last) |=> tc);

  // R6: a one-shot block drops its own enable
  a_r6_self_clear: assert property (@(posedge clk) disable iff (rst)
    (elem_done && cnt_last && !ctrl.circ) |=> !ctrl.en);

  // R10: the programmed count cannot change while enabled
  a_r10_count_lock: assert property (@(posedge clk) disable iff (rst)
    ctrl.en |=> $stable(cnt_init));

endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
  import dma_xfer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req_en,
  input  logic per_req,
  input  logic cnt_nz,
  input  logic cnt_last,
  input  logic steal,
  input  logic bus_grant,
  output logic bus_req,
  output logic rd_phase,
  output logic wr_phase
);

  seq_st_t st, nx;

  always_comb begin
    nx = st;
    case (st)
      SQ_IDLE: if (en && req_en && per_req && cnt_nz) nx = SQ_REQ;
      SQ_REQ: begin
        if (!en)            nx = SQ_IDLE;
        else if (bus_grant) nx = SQ_RD;
      end
      SQ_RD:   nx = SQ_WR;
      SQ_WR:   nx = (cnt_last || steal) ? SQ_IDLE : SQ_RD;
      default: nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      bus_req  <= 1'b0;
      rd_phase <= 1'b0;
      wr_phase <= 1'b0;
    end else begin
      st       <= nx;
      bus_req  <= (nx != SQ_IDLE);
      rd_phase <= (nx == SQ_RD);
      wr_phase <= (nx == SQ_WR);
    end
  end

  // R2: a new bus request needs enable, request enable, a request and work
  a_r2_req_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(en && req_en && per_req && cnt_nz));

  // R11: an empty count never leads to a request
  a_r11_zero_count: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && !cnt_nz) |=> !bus_req);

  // R8: cycle stealing lets go of the bus after each element
  a_r8_steal_release: assert property (@(posedge clk) disable iff (rst)
    (wr_phase && steal) |=> !bus_req);

  // R8: burst keeps the bus while elements remain
  a_r8_burst_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_phase && !steal && !cnt_last) |=> bus_req);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              per_req,
  output logic              per_ack,
  output logic [ADDR_W-1:0] per_addr,
  output logic              per_rd,
  output logic              per_wr,
  output logic [31:0]       per_wdata,
  input  logic [31:0]       per_rdata
);

  localparam int NSIDE = 2;  // index 0 peripheral, 1 memory

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  cnt;
  logic              tc, cnt_nz, cnt_last, wrap, ld_per, ld_mem;
  logic              rd_phase, wr_phase;
  logic [ADDR_W-1:0] cur [NSIDE];
  logic [2:0]        step;

  assign step = step_of(ctrl.size);

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_grant(bus_grant), .elem_done(wr_phase),
    .per_cur(cur[0]), .mem_cur(cur[1]),
    .ctrl(ctrl), .cnt(cnt), .tc(tc), .irq(irq),
    .cnt_nz(cnt_nz), .cnt_last(cnt_last), .wrap(wrap),
    .ld_per(ld_per), .ld_mem(ld_mem)
  );

  dma_bus_seq u_seq (
    .clk(clk), .rst(rst),
    .en(ctrl.en), .req_en(ctrl.req_en), .per_req(per_req),
    .cnt_nz(cnt_nz), .cnt_last(cnt_last), .steal(ctrl.steal),
    .bus_grant(bus_grant),
    .bus_req(bus_req), .rd_phase(rd_phase), .wr_phase(wr_phase)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst(rst),
      .ld((s == 0) ? ld_per : ld_mem),
      .ld_val(cpu_wdata[ADDR_W-1:0]),
      .adv(wr_phase && ((s == 0) ? ctrl.pinc : ctrl.minc)),
      .step(step),
      .wrap(wrap),
      .cur(cur[s])
    );
  end

  assign per_addr  = cur[0];
  assign mem_addr  = cur[1];
  assign per_rd    = rd_phase && !ctrl.dir;
  assign mem_rd    = rd_phase &&  ctrl.dir;
  assign mem_wr    = wr_phase && !ctrl.dir;
  assign per_wr    = wr_phase &&  ctrl.dir;
  assign per_ack   = wr_phase;
  assign mem_wdata = lane_mask(ctrl.size, per_rdata);
  assign per_wdata = lane_mask(ctrl.size, mem_rdata);

  // R2: strobes only while the bus is owned
  a_r2_strobe_grant: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr || per_rd || per_wr) |-> bus_grant);

  // R3: every destination write is preceded by a source read
  a_r3_wr_after_rd: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || per_wr) |-> $past(mem_rd || per_rd));

endmodule

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 6;

  localparam int C_EN = 1, C_RQ = 2, C_IE = 4, C_CIRC = 8, C_STEAL = 16;
  localparam int C_DIR = 32, C_PINC = 64, C_MINC = 128;

  logic clk = 0, rst = 1;
  logic cpu_sel = 0, cpu_wr = 0;
  logic [2:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic irq, bus_req, bus_grant;
  logic [ADDR_W-1:0] mem_addr, per_addr;
  logic mem_rd, mem_wr, per_rd, per_wr, per_ack;
  logic [31:0] mem_wdata, mem_rdata, per_wdata, per_rdata;
  logic per_req = 0;

  int checks = 0, errors = 0;
  int rises = 0, wr_seen = 0;
  logic req_prev = 0;
  logic [ADDR_W-1:0] exp_ra[$];
  logic [ADDR_W-1:0] exp_wa[$];
  logic [31:0]       exp_wd[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dma_xfer_engine (
    .clk(clk), .rst(rst),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_ack(per_ack), .per_addr(per_addr),
    .per_rd(per_rd), .per_wr(per_wr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  function automatic logic [31:0] pat_p(input logic [ADDR_W-1:0] a);
    return 32'h1357_9BDF ^ ({16'h0, a} * 32'h0101_0101);
  endfunction
  function automatic logic [31:0] pat_m(input logic [ADDR_W-1:0] a);
    return 32'hA5C3_0F69 + ({16'h0, a} * 32'h0003_0507);
  endfunction
  function automatic logic [31:0] msk(input int sz, input logic [31:0] d);
    return (sz == 0) ? (d & 32'hFF) : (sz == 1) ? (d & 32'hFFFF) : d;
  endfunction

  // Environment: processor grants the bus one cycle after a request; sync slaves
  always @(posedge clk) begin
    bus_grant <= rst ? 1'b0 : bus_req;
    if (mem_rd) mem_rdata <= pat_m(mem_addr);
    if (per_rd) per_rdata <= pat_p(per_addr);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the transaction model
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !req_prev) rises++;
      req_prev = bus_req;
      if ((mem_rd || mem_wr || per_rd || per_wr) && !bus_grant)
        check("R2 strobe without grant", 1, 0);
      if (mem_rd || per_rd) begin
        if (exp_ra.size() == 0) check("R3 unexpected read", 1, 0);
        else check("R4 read address", mem_rd ? mem_addr : per_addr, exp_ra.pop_front());
      end
      if (mem_wr || per_wr) begin
        wr_seen++;
        if (exp_wa.size() == 0) check("R3 unexpected write", 1, 0);
        else begin
          check("R4 write address", mem_wr ? mem_addr : per_addr, exp_wa.pop_front());
          check("R3 write data", mem_wr ? mem_wdata : per_wdata, exp_wd.pop_front());
        end
      end
    end
  end

  task automatic plan(input bit dir, input int sz, input bit pinc, input bit minc,
                      input int pa, input int ma, input int n, input int reps);
    int st = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int r = 0; r < reps; r++)
      for (int k = 0; k < n; k++) begin
        logic [ADDR_W-1:0] pk = ADDR_W'(pa + (pinc ? k * st : 0));
        logic [ADDR_W-1:0] mk = ADDR_W'(ma + (minc ? k * st : 0));
        exp_ra.push_back(dir ? mk : pk);
        exp_wa.push_back(dir ? pk : mk);
        exp_wd.push_back(msk(sz, dir ? pat_m(mk) : pat_p(pk)));
      end
  endtask

  task automatic fresh();
    exp_ra.delete(); exp_wa.delete(); exp_wd.delete();
    rises = 0; wr_seen = 0;
  endtask

  task automatic cpu_write(input int a, input int d);
    @(negedge clk);
    while (bus_grant) @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 3'(a); cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input int a, output logic [31:0] d);
    @(negedge clk);
    while (bus_grant) @(negedge clk);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = 3'(a);
    @(negedge clk);
    d = cpu_rdata;
    cpu_sel = 0;
  endtask

  task automatic setup(input int mode, input int cnt, input int pa, input int ma);
    cpu_write(0, mode);
    cpu_write(2, cnt);
    cpu_write(3, pa);
    cpu_write(4, ma);
    cpu_write(0, mode | C_EN);
  endtask

  task automatic wait_done(input int n, input string tag);
    int t = 0;
    @(negedge clk);
    while ((wr_seen < n || bus_req || bus_grant) && t < 3000) begin
      @(negedge clk); t++;
    end
    check({tag, " block finished"}, (t < 3000) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    check("R1 bus_req", bus_req, 0);
    check("R1 irq", irq, 0);
    for (int a = 0; a < 5; a++) begin
      cpu_read(a, d);
      check("R1 register", d, 0);
    end

    // Test A: per->mem, 8-bit, fixed per address, burst, irq enabled
    fresh();
    plan(0, 0, 0, 1, 'h100, 'h200, 4, 1);
    setup(C_RQ | C_IE | C_MINC, 4, 'h100, 'h200);
    per_req = 1;
    wait_done(4, "R3");
    per_req = 0;
    check("R8 burst single request", rises, 1);
    check("R3 all elements", exp_wa.size(), 0);
    cpu_read(0, d); check("R6 enable cleared", d[0], 0);
    cpu_read(2, d); check("R6 count zero", d, 0);
    cpu_read(1, d); check("R5 flag set", d[0], 1);
    check("R5 irq", irq, 1);
    cpu_read(4, d); check("R4 memory address advanced", d, 'h204);
    cpu_read(3, d); check("R4 peripheral address fixed", d, 'h100);
    cpu_write(1, 1);
    cpu_read(1, d); check("R5 flag cleared", d[0], 0);
    check("R5 irq cleared", irq, 0);

    // Test B: mem->per, 32-bit, both increment, cycle stealing, no irq
    fresh();
    plan(1, 2, 1, 1, 'h40, 'h80, 3, 1);
    setup(C_RQ | C_DIR | C_PINC | C_MINC | C_STEAL | (2 << 8), 3, 'h40, 'h80);
    per_req = 1;
    wait_done(3, "R8");
    per_req = 0;
    check("R8 request per element", rises, 3);
    check("R3 all elements", exp_wa.size(), 0);
    cpu_read(3, d); check("R4 32-bit step", d, 'h4C);
    cpu_read(1, d); check("R5 flag set", d[0], 1);
    check("R5 irq masked", irq, 0);
    cpu_write(1, 1);

    // Test C: circular, 16-bit, cycle stealing
    fresh();
    plan(0, 1, 1, 1, 'h10, 'h30, 2, 8);
    setup(C_RQ | C_CIRC | C_STEAL | C_PINC | C_MINC | (1 << 8), 2, 'h10, 'h30);
    per_req = 1;
    begin
      int t = 0;
      while (wr_seen < 5 && t < 3000) begin @(negedge clk); t++; end
    end
    per_req = 0;
    repeat (12) @(negedge clk);
    check("R7 service continued past block end", (wr_seen >= 5) ? 1 : 0, 1);
    cpu_read(0, d); check("R7 enable kept", d[0], 1);
    cpu_read(1, d); check("R7 flag set on wrap", d[0], 1);
    cpu_write(0, 0);
    cpu_write(1, 1);

    // Test D: masked requests and locked configuration
    fresh();
    plan(0, 0, 1, 1, 'h20, 'h60, 5, 1);
    setup(C_PINC | C_MINC, 5, 'h20, 'h60);
    per_req = 1;
    repeat (20) @(negedge clk);
    check("R9 no request while masked", rises, 0);
    cpu_write(2, 9);
    cpu_write(4, 'h77);
    cpu_read(2, d); check("R10 count locked", d, 5);
    cpu_read(4, d); check("R10 address locked", d, 'h60);
    cpu_write(0, C_EN | C_RQ | C_PINC | C_MINC | (2 << 8));
    wait_done(5, "R9");
    per_req = 0;
    check("R3 all elements", exp_wa.size(), 0);
    cpu_read(0, d); check("R10 size field locked", d[9:8], 0);
    cpu_read(4, d); check("R10 old step used", d, 'h65);

    // Test E: zero count
    fresh();
    cpu_write(2, 0);
    cpu_write(0, C_EN | C_RQ);
    per_req = 1;
    repeat (20) @(negedge clk);
    check("R11 no request for zero count", rises, 0);
    check("R11 bus_req low", bus_req, 0);
    per_req = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule